// File: doc/BRIEF.md
# Packed XOR-Rotate Vector Unit

This unit decodes one 32-bit instruction word and runs a lane-wise exclusive-OR followed by a rotate-right on two vector operands of parameterised width `VL`. `VL` must be a multiple of 64. The element width and the rotate distance both come from a single packed immediate. A 4-bit size code selects the element width through its highest set bit. The rotate distance is twice the element width minus the 7-bit value formed by the size code followed by three more immediate bits.

The result is meant to be written back over the first source register. For that reason the unit reports a single destination index, and that index also names the first operand. It also reports the index of the second source. Every element across the vector is produced, because the operation has no mask.

An instruction word whose fixed opcode bits differ from the expected pattern raises a no-match output. A matching word whose size code is zero raises an undefined-instruction output. In both cases the result is zero. All outputs are registered one clock after the valid strobe.

Top module: `xorrot_vec_unit`

## Requirements
- R1: The word matches only when bits 31:24 equal 8'h04, bit 21 is 1 and bits 15:10 equal 6'b001101. Any other word gives nomatch_flag=1, undef_flag=0 and result=0.
- R2: For a matching word whose size code {insn[23:22], insn[20:19]} is 4'b0000, undef_flag=1, nomatch_flag=0 and result=0.
- R3: The element width is 8 shifted left by the position of the highest set bit of the size code. Code 1 gives 8, codes 2–3 give 16, codes 4–7 give 32 and codes 8–15 give 64.
- R4: The rotate distance is 2×width minus the unsigned value {size code, insn[18:16]}. It always lies between 1 and the element width.
- R5: Element e occupies result bits [e×width +: width]. It equals (a_e XOR b_e) rotated right by the rotate distance. All VL/width elements are written, with no masking.
- R6: When the rotate distance equals the element width, the result equals opnd_a XOR opnd_b unchanged.
- R7: dst_idx takes insn[4:0], which names both the destination and the first source. src2_idx takes insn[9:5].
- R8: out_valid is high exactly one cycle after each in_valid. The other outputs update only on in_valid and otherwise hold their values.
- R9: A synchronous active-high rst clears every output to zero on the next clock edge, and it takes priority over in_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| insn | input | 32 | Instruction word |
| opnd_a | input | VL | First source vector |
| opnd_b | input | VL | Second source vector |
| out_valid | output | 1 | Registered valid, one cycle after in_valid |
| result | output | VL | XOR-rotated vector, zero when the word is illegal |
| dst_idx | output | 5 | Destination index, which is also the first source index |
| src2_idx | output | 5 | Second source index |
| undef_flag | output | 1 | Matching word with a zero size code |
| nomatch_flag | output | 1 | Fixed opcode bits did not match |

## Verification
A wrong highest-bit decode or a wrong subtraction in the rotate distance shows up at the result port one cycle after the strobe. It appears as elements of the wrong width or as bits displaced by a fixed offset. Every legal size code is swept with all eight low immediate values, so an off-by-one in either path is caught on the first affected pair. A lost or stuck valid, or a flag left over from the previous word, appears in the very next output cycle. That cycle is where the bench samples.

// File: rtl/xorrot_pkg.sv
package xorrot_pkg;

  localparam logic [7:0] XR_OPC_TOP = 8'h04;
  localparam logic [5:0] XR_OPC_MID = 6'b001101;

  typedef struct packed {
    logic       match;
    logic       undef;
    logic [1:0] size_idx;
    logic [6:0] esize;
    logic [6:0] rot;
    logic [4:0] zdn;
    logic [4:0] zm;
  } xr_dec_t;

  function automatic logic xr_opcode_ok(input logic [31:0] w);
    return (w[31:24] == XR_OPC_TOP) && w[21] && (w[15:10] == XR_OPC_MID);
  endfunction

  function automatic logic [3:0] xr_size_code(input logic [31:0] w);
    return {w[23:22], w[20:19]};
  endfunction

  // position of the highest set bit; zero for codes 0 and 1
  function automatic logic [1:0] xr_size_idx(input logic [3:0] ts);
    if (ts[3])      return 2'd3;
    else if (ts[2]) return 2'd2;
    else if (ts[1]) return 2'd1;
    else            return 2'd0;
  endfunction

  function automatic logic [6:0] xr_esize(input logic [3:0] ts);
    return 7'd8 << xr_size_idx(ts);
  endfunction

  function automatic logic [6:0] xr_rot_amt(input logic [3:0] ts, input logic [2:0] i3);
    logic [7:0] twice;
    twice = {xr_esize(ts), 1'b0};
    return 7'(twice - {1'b0, ts, i3});
  endfunction

endpackage

// File: rtl/xorrot_rotr.sv
module xorrot_rotr #(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = $clog2(W)
) (
  input  logic [W-1:0]  d,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  q
);
  logic [2*W-1:0] dbl;
  // a distance equal to W wraps to zero in AW bits: full circle
  assign dbl = {d, d} >> amt;
  assign q   = dbl[W-1:0];
endmodule

// File: rtl/xorrot_lane.sv
module xorrot_lane #(
  parameter int unsigned LW = 64
) (
  input  logic [LW-1:0] x,
  input  logic [1:0]    size_idx,
  input  logic [5:0]    rot,
  output logic [LW-1:0] y
);
  localparam int unsigned NSZ = 4;

  logic [NSZ-1:0][LW-1:0] cand;

  for (genvar s = 0; s < NSZ; s++) begin : g_sz
    localparam int unsigned EW = 8 << s;
    localparam int unsigned NE = LW / EW;
    localparam int unsigned AW = $clog2(EW);
    for (genvar k = 0; k < NE; k++) begin : g_el
      xorrot_rotr #(.W(EW)) u_rot (
        .d  (x[k*EW +: EW]),
        .amt(rot[AW-1:0]),
        .q  (cand[s][k*EW +: EW])
      );
    end
  end

  assign y = cand[size_idx];
endmodule

// File: rtl/xorrot_decode.sv
module xorrot_decode
  import xorrot_pkg::*;
(
  input  logic [31:0] insn,
  output xr_dec_t     dec
);
  logic [3:0] ts;

  assign ts = xr_size_code(insn);

  always_comb begin
    dec.match    = xr_opcode_ok(insn);
    dec.undef    = (ts == 4'b0000);
    dec.size_idx = xr_size_idx(ts);
    dec.esize    = xr_esize(ts);
    dec.rot      = xr_rot_amt(ts, insn[18:16]);
    dec.zdn      = insn[4:0];
    dec.zm       = insn[9:5];
  end
endmodule

// File: rtl/xorrot_vec_unit.sv
module xorrot_vec_unit
  import xorrot_pkg::*;
#(
  parameter int unsigned VL = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [31:0]   insn,
  input  logic [VL-1:0] opnd_a,
  input  logic [VL-1:0] opnd_b,
  output logic          out_valid,
  output logic [VL-1:0] result,
  output logic [4:0]    dst_idx,
  output logic [4:0]    src2_idx,
  output logic          undef_flag,
  output logic          nomatch_flag
);
  localparam int unsigned CHUNK = 64;
  localparam int unsigned NCH   = VL / CHUNK;

  xr_dec_t       dec;
  logic          op_legal;
  logic [6:0]    dec_esize;
  logic [6:0]    dec_rot;
  logic [VL-1:0] mixed;
  logic [VL-1:0] rotated;

  xorrot_decode u_dec (
    .insn(insn),
    .dec (dec)
  );

  assign op_legal  = dec.match & ~dec.undef;
  assign dec_esize = dec.esize;
  assign dec_rot   = dec.rot;
  assign mixed     = opnd_a ^ opnd_b;

  // each 64-bit chunk holds whole elements of every width
  for (genvar c = 0; c < NCH; c++) begin : g_chunk
    xorrot_lane #(.LW(CHUNK)) u_lane (
      .x       (mixed[c*CHUNK +: CHUNK]),
      .size_idx(dec.size_idx),
      .rot     (dec_rot[5:0]),
      .y       (rotated[c*CHUNK +: CHUNK])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      result       <= '0;
      dst_idx      <= '0;
      src2_idx     <= '0;
      undef_flag   <= 1'b0;
      nomatch_flag <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result       <= op_legal ? rotated : '0;
        dst_idx      <= dec.zdn;
        src2_idx     <= dec.zm;
        undef_flag   <= dec.match & dec.undef;
        nomatch_flag <= ~dec.match;
      end
    end
  end
endmodule

// File: rtl/xorrot_chk.sv
module xorrot_chk #(
  parameter int unsigned VL = 128
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [31:0]   insn,
  input logic [VL-1:0] opnd_a,
  input logic [VL-1:0] opnd_b,
  input logic          out_valid,
  input logic [VL-1:0] result,
  input logic [4:0]    dst_idx,
  input logic [4:0]    src2_idx,
  input logic          undef_flag,
  input logic          nomatch_flag,
  input logic          op_legal,
  input logic [6:0]    dec_esize,
  input logic [6:0]    dec_rot
);
  logic fixed_ok;
  assign fixed_ok = (insn[31:24] == 8'h04) && insn[21] && (insn[15:10] == 6'b001101);

  a_r1_nomatch_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !fixed_ok) |=> (nomatch_flag && !undef_flag && result == '0));

  a_r2_undef_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fixed_ok && {insn[23:22], insn[20:19]} == 4'b0000)
      |=> (undef_flag && !nomatch_flag && result == '0));

  a_r3_width_onehot: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ($countones(dec_esize) == 1 && dec_esize >= 7'd8 && dec_esize <= 7'd64));

  a_r4_rot_range: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_legal) |-> (dec_rot >= 7'd1 && dec_rot <= dec_esize));

  a_r6_full_circle: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_legal && dec_rot == dec_esize) |=> (result == $past(opnd_a ^ opnd_b)));

  a_r7_indices: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (dst_idx == $past(insn[4:0]) && src2_idx == $past(insn[9:5])));

  a_r8_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) && $stable(dst_idx)));

  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0 && !undef_flag && !nomatch_flag));
endmodule

bind xorrot_vec_unit xorrot_chk #(.VL(VL)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .insn        (insn),
  .opnd_a      (opnd_a),
  .opnd_b      (opnd_b),
  .out_valid   (out_valid),
  .result      (result),
  .dst_idx     (dst_idx),
  .src2_idx    (src2_idx),
  .undef_flag  (undef_flag),
  .nomatch_flag(nomatch_flag),
  .op_legal    (op_legal),
  .dec_esize   (dec_esize),
  .dec_rot     (dec_rot)
);

// File: tb/sim_xorrot_vec_unit.sv
`timescale 1ns/1ps
module sim_xorrot_vec_unit;
  localparam int unsigned VL = 128;

  typedef struct packed {
    logic [31:0] insn;
    logic        undef;
    logic        nom;
    logic [6:0]  es;
    logic [6:0]  rot;
  } vec_t;

  function automatic logic [31:0] mk(input logic [1:0] hi, input logic [1:0] lo,
                                     input logic [2:0] i3, input logic [4:0] zm,
                                     input logic [4:0] zdn);
    return {8'h04, hi, 1'b1, lo, i3, 6'b001101, zm, zdn};
  endfunction

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{mk(2'b00, 2'b01, 3'd0, 5'd3,  5'd31), 1'b0, 1'b0, 7'd8,  7'd8},
    '{mk(2'b00, 2'b01, 3'd7, 5'd4,  5'd30), 1'b0, 1'b0, 7'd8,  7'd1},
    '{mk(2'b00, 2'b10, 3'd0, 5'd5,  5'd29), 1'b0, 1'b0, 7'd16, 7'd16},
    '{mk(2'b00, 2'b11, 3'd7, 5'd6,  5'd28), 1'b0, 1'b0, 7'd16, 7'd1},
    '{mk(2'b01, 2'b00, 3'd3, 5'd7,  5'd27), 1'b0, 1'b0, 7'd32, 7'd29},
    '{mk(2'b01, 2'b11, 3'd7, 5'd8,  5'd26), 1'b0, 1'b0, 7'd32, 7'd1},
    '{mk(2'b10, 2'b00, 3'd0, 5'd9,  5'd25), 1'b0, 1'b0, 7'd64, 7'd64},
    '{mk(2'b11, 2'b11, 3'd7, 5'd10, 5'd24), 1'b0, 1'b0, 7'd64, 7'd1},
    '{mk(2'b10, 2'b10, 3'd5, 5'd11, 5'd23), 1'b0, 1'b0, 7'd64, 7'd43},
    '{mk(2'b00, 2'b00, 3'd5, 5'd12, 5'd22), 1'b1, 1'b0, 7'd8,  7'd8},
    '{mk(2'b00, 2'b01, 3'd1, 5'd13, 5'd21) ^ 32'h0020_0000, 1'b0, 1'b1, 7'd8, 7'd8},
    '{mk(2'b01, 2'b00, 3'd2, 5'd14, 5'd20) ^ 32'h0100_0000, 1'b0, 1'b1, 7'd8, 7'd8},
    '{mk(2'b10, 2'b00, 3'd4, 5'd15, 5'd19) ^ 32'h0000_1000, 1'b0, 1'b1, 7'd8, 7'd8}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [31:0]   insn = '0;
  logic [VL-1:0] opnd_a = '0;
  logic [VL-1:0] opnd_b = '0;
  logic          out_valid;
  logic [VL-1:0] result;
  logic [4:0]    dst_idx;
  logic [4:0]    src2_idx;
  logic          undef_flag;
  logic          nomatch_flag;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  xorrot_vec_unit #(.VL(VL)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .result(result),
    .dst_idx(dst_idx), .src2_idx(src2_idx), .undef_flag(undef_flag),
    .nomatch_flag(nomatch_flag)
  );

  // bit i of a rotated-right element is source bit (i + rot) mod width
  function automatic logic [VL-1:0] ref_xr(input logic [VL-1:0] a, input logic [VL-1:0] b,
                                           input int es, input int rot);
    logic [VL-1:0] x;
    logic [VL-1:0] r;
    x = a ^ b;
    r = '0;
    for (int e = 0; e < VL / es; e++)
      for (int i = 0; i < es; i++)
        r[e*es + i] = x[e*es + ((i + rot) % es)];
    return r;
  endfunction

  function automatic logic [VL-1:0] rnd_vec();
    logic [VL-1:0] v;
    for (int k = 0; k < VL / 32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic chk(input string req, input logic [VL-1:0] act, input logic [VL-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic [VL-1:0] a, input logic [VL-1:0] b);
    @(negedge clk);
    in_valid = 1'b1; insn = w; opnd_a = a; opnd_b = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [VL-1:0] a, b, exp, held;
    logic [4:0]    held_dst;
    int            es, rot;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk("R9 valid", VL'(out_valid), '0);
    chk("R9 result", result, '0);
    chk("R9 flags", VL'({undef_flag, nomatch_flag}), '0);

    // table walk: R1 R2 R3 R4 R5 R6 R7 R8
    for (int t = 0; t < NV; t++) begin
      a = rnd_vec(); b = rnd_vec();
      issue(TBL[t].insn, a, b);
      exp = (TBL[t].undef || TBL[t].nom) ? '0 : ref_xr(a, b, TBL[t].es, TBL[t].rot);
      chk("R5 table result", result, exp);
      chk("R1 nomatch", VL'(nomatch_flag), VL'(TBL[t].nom));
      chk("R2 undef", VL'(undef_flag), VL'(TBL[t].undef));
      chk("R7 dst", VL'(dst_idx), VL'(TBL[t].insn[4:0]));
      chk("R7 src2", VL'(src2_idx), VL'(TBL[t].insn[9:5]));
      chk("R8 out_valid", VL'(out_valid), VL'(1));
      if (!TBL[t].undef && !TBL[t].nom && TBL[t].rot == TBL[t].es)
        chk("R6 full circle", result, a ^ b);
    end

    // sweep every legal size code and low immediate: R3 R4 R5
    for (int ts = 1; ts < 16; ts++) begin
      for (int i3 = 0; i3 < 8; i3++) begin
        es = 8;
        for (int p = 0; p < 4; p++) if (ts[p]) es = 8 << p;
        rot = 2 * es - (ts * 8 + i3);
        a = rnd_vec(); b = rnd_vec();
        issue(mk(2'(ts >> 2), 2'(ts), 3'(i3), 5'(i3), 5'(ts)), a, b);
        chk("R5 sweep result", result, ref_xr(a, b, es, rot));
        chk("R3 R4 sweep flags", VL'({undef_flag, nomatch_flag}), '0);
      end
    end

    // R8 hold while idle
    a = rnd_vec(); b = rnd_vec();
    issue(mk(2'b01, 2'b10, 3'd2, 5'd1, 5'd2), a, b);
    held = result; held_dst = dst_idx;
    @(negedge clk);
    insn = mk(2'b11, 2'b00, 3'd0, 5'd9, 5'd9); opnd_a = rnd_vec();
    @(negedge clk);
    chk("R8 idle valid", VL'(out_valid), '0);
    chk("R8 idle result hold", result, held);
    chk("R8 idle dst hold", VL'(dst_idx), VL'(held_dst));

    // R9 reset beats a concurrent valid
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; insn = mk(2'b00, 2'b01, 3'd3, 5'd7, 5'd7);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    chk("R9 rst valid", VL'(out_valid), '0);
    chk("R9 rst result", result, '0);
    chk("R9 rst idx", VL'({dst_idx, src2_idx}), '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule